// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block joins an A bus and a B bus through two independent register paths, one for each direction. Each path has a storage element that can work in three ways. It can be transparent, so that its output follows its input. It can hold a stored value. It can capture its input on a falling transition of a per-path capture control. The bus width is split into independent sections. Every section has its own output enable, latch-open control and capture control for each direction.

The block runs on a system clock `clk`. The capture controls are sampled on that clock. A falling transition is seen when the control is high at one rising clock edge and low at the next. The latch-open controls act at once: while one is high, the path output is a combinational copy of its input. The storage also reloads on every clock edge while the latch is open, so closing it keeps the most recent value. The pins stay as plain signals: each direction has separate input and output buses plus a per-section drive-enable. A pad wrapper one level up builds the three-state pins from these. When both directions of one section drive at the same time, the block raises a contention flag for that section and leaves both paths working as normal.

Top module: `ubt_transceiver`

## Requirements
- R1: While `abLatchOpen[s]` is high and section s drives B, the slice `bOut[s*WIDTH +: WIDTH]` equals the matching `aIn` slice in the same cycle. Likewise `aOut` follows `bIn` while `baLatchOpen[s]` is high and section s drives A.
- R2: While a path's latch-open control is low and its capture control holds the same level across consecutive clock edges, the path output does not change, whatever its input bus does.
- R3: With the latch-open control low at the clock edge where a fall of the capture control is seen (high at the previous rising edge, low at this one), the path stores its input bus as sampled at this edge. The stored value appears at the output from that edge on.
- R4: `abEnable[s]` is active high. When it is low, `bDrive[s]` is 0 and the `bOut` slice of section s is all zeros, whatever the other controls are.
- R5: `baEnableN[s]` is active low. When it is high, `aDrive[s]` is 0 and the `aOut` slice of section s is all zeros. Apart from this, the B-to-A path behaves exactly like the A-to-B path, using `baLatchOpen` and `baCapture`.
- R6: Sections are independent. Section s uses only bits `[s*WIDTH +: WIDTH]` of the data buses and index s of every control, drive and flag vector.
- R7: When a latch-open control falls, the path keeps the input value sampled at the last clock edge at which that latch was open. If the capture control is low or stays low, that value stays at the output.
- R8: `contention[s]` is high exactly when `abEnable[s]` is high and `baEnableN[s]` is low. Both outputs of that section still follow their own paths.
- R9: An active-low asynchronous reset `rstN` clears every stored value to zero and clears the capture history to low, so the first clock edge after reset sees no fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples capture controls and loads storage |
| rstN | input | 1 | Asynchronous active-low reset |
| abEnable | input | SECTIONS | A-to-B output enable per section, active high |
| baEnableN | input | SECTIONS | B-to-A output enable per section, active low |
| abLatchOpen | input | SECTIONS | A-to-B transparent mode when high |
| baLatchOpen | input | SECTIONS | B-to-A transparent mode when high |
| abCapture | input | SECTIONS | A-to-B capture control, stores on falling transition |
| baCapture | input | SECTIONS | B-to-A capture control, stores on falling transition |
| aIn | input | SECTIONS*WIDTH | Value seen on the A pins |
| bIn | input | SECTIONS*WIDTH | Value seen on the B pins |
| aOut | output | SECTIONS*WIDTH | Data to drive onto the A pins, zero when not driving |
| bOut | output | SECTIONS*WIDTH | Data to drive onto the B pins, zero when not driving |
| aDrive | output | SECTIONS | Drive-enable for each A section |
| bDrive | output | SECTIONS | Drive-enable for each B section |
| contention | output | SECTIONS | Both directions of a section enabled at once |

## Verification
A capture fall and a change of the latch-open control can land at the same clock edge. In the same cycle the output enable can also change, so the stored value, the transparent bypass and the drive gating all move at once. Long random runs toggle the capture controls about every other cycle and open the latch about a quarter of the time, with each section and direction drawn on its own, so these meetings happen thousands of times. Each outcome is judged against a bench model that updates its stored values at each rising edge and derives the expected outputs from the current controls. A reset pulse in the middle of the run also checks that a capture control left high does not cause a false fall when reset is released.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  // strobes for one direction of one section
  typedef struct packed {
    logic pass;   // bypass storage, output follows input
    logic load;   // storage takes the input at this clock edge
    logic drive;  // output is enabled
  } pathStrobeT;

  typedef struct packed {
    pathStrobeT ab;
    pathStrobeT ba;
  } sectStrobeT;

endpackage

// File: rtl/ubt_control.sv
module ubt_control
  import ubt_pkg::*;
#(
  parameter int SECTIONS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [SECTIONS-1:0]            abEnable,
  input  logic [SECTIONS-1:0]            baEnableN,
  input  logic [SECTIONS-1:0]            abLatchOpen,
  input  logic [SECTIONS-1:0]            baLatchOpen,
  input  logic [SECTIONS-1:0]            abCapture,
  input  logic [SECTIONS-1:0]            baCapture,
  output sectStrobeT [SECTIONS-1:0]      strobe,
  output logic [SECTIONS-1:0]            contention
);

  // capture control levels seen at the previous clock edge
  logic [SECTIONS-1:0] abCapPrev;
  logic [SECTIONS-1:0] baCapPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abCapPrev <= '0;
      baCapPrev <= '0;
    end else begin
      abCapPrev <= abCapture;
      baCapPrev <= baCapture;
    end
  end

  always_comb begin
    for (int s = 0; s < SECTIONS; s++) begin
      strobe[s].ab.pass  = abLatchOpen[s];
      strobe[s].ab.load  = abLatchOpen[s] | (abCapPrev[s] & ~abCapture[s]);
      strobe[s].ab.drive = abEnable[s];
      strobe[s].ba.pass  = baLatchOpen[s];
      strobe[s].ba.load  = baLatchOpen[s] | (baCapPrev[s] & ~baCapture[s]);
      strobe[s].ba.drive = ~baEnableN[s];
    end
  end

  assign contention = abEnable & ~baEnableN;

endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathStrobeT       strb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);

  logic [WIDTH-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          held <= '0;
    else if (strb.load) held <= din;
  end

  assign dout  = strb.drive ? (strb.pass ? din : held) : '0;
  assign drive = strb.drive;

endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath
  import ubt_pkg::*;
#(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 18,
  localparam int TOTAL   = SECTIONS * WIDTH
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sectStrobeT [SECTIONS-1:0] strobe,
  input  logic [TOTAL-1:0]          aIn,
  input  logic [TOTAL-1:0]          bIn,
  output logic [TOTAL-1:0]          aOut,
  output logic [TOTAL-1:0]          bOut,
  output logic [SECTIONS-1:0]       aDrive,
  output logic [SECTIONS-1:0]       bDrive
);

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
    ubt_path #(.WIDTH(WIDTH)) abPath_i (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strobe[s].ab),
      .din   (aIn[s*WIDTH +: WIDTH]),
      .dout  (bOut[s*WIDTH +: WIDTH]),
      .drive (bDrive[s])
    );
    ubt_path #(.WIDTH(WIDTH)) baPath_i (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strobe[s].ba),
      .din   (bIn[s*WIDTH +: WIDTH]),
      .dout  (aOut[s*WIDTH +: WIDTH]),
      .drive (aDrive[s])
    );
  end

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
  import ubt_pkg::*;
#(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 18,
  localparam int TOTAL   = SECTIONS * WIDTH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SECTIONS-1:0] abEnable,
  input  logic [SECTIONS-1:0] baEnableN,
  input  logic [SECTIONS-1:0] abLatchOpen,
  input  logic [SECTIONS-1:0] baLatchOpen,
  input  logic [SECTIONS-1:0] abCapture,
  input  logic [SECTIONS-1:0] baCapture,
  input  logic [TOTAL-1:0]    aIn,
  input  logic [TOTAL-1:0]    bIn,
  output logic [TOTAL-1:0]    aOut,
  output logic [TOTAL-1:0]    bOut,
  output logic [SECTIONS-1:0] aDrive,
  output logic [SECTIONS-1:0] bDrive,
  output logic [SECTIONS-1:0] contention
);

  sectStrobeT [SECTIONS-1:0] strobe;

  ubt_control #(.SECTIONS(SECTIONS)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .abEnable    (abEnable),
    .baEnableN   (baEnableN),
    .abLatchOpen (abLatchOpen),
    .baLatchOpen (baLatchOpen),
    .abCapture   (abCapture),
    .baCapture   (baCapture),
    .strobe      (strobe),
    .contention  (contention)
  );

  ubt_datapath #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) datapath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .bOut   (bOut),
    .aDrive (aDrive),
    .bDrive (bDrive)
  );

endmodule

// File: rtl/ubt_transceiver_chk.sv
module ubt_transceiver_chk #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 18,
  localparam int TOTAL   = SECTIONS * WIDTH
) (
  input logic                clk,
  input logic                rstN,
  input logic [SECTIONS-1:0] abEnable,
  input logic [SECTIONS-1:0] baEnableN,
  input logic [SECTIONS-1:0] abLatchOpen,
  input logic [SECTIONS-1:0] baLatchOpen,
  input logic [SECTIONS-1:0] abCapture,
  input logic [SECTIONS-1:0] baCapture,
  input logic [TOTAL-1:0]    aIn,
  input logic [TOTAL-1:0]    bIn,
  input logic [TOTAL-1:0]    aOut,
  input logic [TOTAL-1:0]    bOut,
  input logic [SECTIONS-1:0] aDrive,
  input logic [SECTIONS-1:0] bDrive,
  input logic [SECTIONS-1:0] contention
);

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    // R1
    ab_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
      (abLatchOpen[s] && abEnable[s]) |-> bOut[s*WIDTH +: WIDTH] == aIn[s*WIDTH +: WIDTH]);
    // R1
    ba_transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
      (baLatchOpen[s] && !baEnableN[s]) |-> aOut[s*WIDTH +: WIDTH] == bIn[s*WIDTH +: WIDTH]);
    // R2
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!abLatchOpen[s] && $past(!abLatchOpen[s]) && abEnable[s] && $past(abEnable[s]) &&
       abCapture[s] == $past(abCapture[s]) && $past(abCapture[s]) == $past(abCapture[s], 2))
      |-> $stable(bOut[s*WIDTH +: WIDTH]));
    // R2
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!baLatchOpen[s] && $past(!baLatchOpen[s]) && !baEnableN[s] && $past(!baEnableN[s]) &&
       baCapture[s] == $past(baCapture[s]) && $past(baCapture[s]) == $past(baCapture[s], 2))
      |-> $stable(aOut[s*WIDTH +: WIDTH]));
    // R3
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!abLatchOpen[s] && $fell(abCapture[s]) && $past(rstN))
      |=> (abLatchOpen[s] || !abEnable[s] || bOut[s*WIDTH +: WIDTH] == $past(aIn[s*WIDTH +: WIDTH])));
    // R3
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!baLatchOpen[s] && $fell(baCapture[s]) && $past(rstN))
      |=> (baLatchOpen[s] || baEnableN[s] || aOut[s*WIDTH +: WIDTH] == $past(bIn[s*WIDTH +: WIDTH])));
    // R4
    ab_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !abEnable[s] |-> (!bDrive[s] && bOut[s*WIDTH +: WIDTH] == '0));
    // R5
    ba_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
      baEnableN[s] |-> (!aDrive[s] && aOut[s*WIDTH +: WIDTH] == '0));
    // R8
    contention_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
      contention[s] |-> (aDrive[s] && bDrive[s]));
  end

endmodule

bind ubt_transceiver ubt_transceiver_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) chk_i (.*);

// File: tb/ubt_transceiver_tb_top.sv
module ubt_transceiver_tb_top;
  localparam int SECTIONS = 2;
  localparam int WIDTH    = 18;
  localparam int TOTAL    = SECTIONS * WIDTH;
  localparam int PERIOD   = 10;
  localparam int CYCLES   = 4000;

  logic                clk = 1'b0;
  logic                rstN;
  logic [SECTIONS-1:0] abEnable, baEnableN, abLatchOpen, baLatchOpen, abCapture, baCapture;
  logic [TOTAL-1:0]    aIn, bIn, aOut, bOut;
  logic [SECTIONS-1:0] aDrive, bDrive, contention;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the stored values, built from R3, R7 and R9
  logic [WIDTH-1:0]    mAb [SECTIONS];
  logic [WIDTH-1:0]    mBa [SECTIONS];
  logic [SECTIONS-1:0] mAbPrev, mBaPrev;
  int                  mAbWhy [SECTIONS];  // 0 none, 1 latch open, 2 fall
  int                  mBaWhy [SECTIONS];

  always #(PERIOD/2) clk = ~clk;

  ubt_transceiver #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) dut_i (.*);

  always @(posedge clk) begin
    for (int s = 0; s < SECTIONS; s++) begin
      if (!rstN) begin
        mAb[s] = '0; mBa[s] = '0; mAbWhy[s] = 0; mBaWhy[s] = 0;
      end else begin
        mAbWhy[s] = 0; mBaWhy[s] = 0;
        if (abLatchOpen[s]) begin mAb[s] = aIn[s*WIDTH +: WIDTH]; mAbWhy[s] = 1; end
        else if (mAbPrev[s] && !abCapture[s]) begin mAb[s] = aIn[s*WIDTH +: WIDTH]; mAbWhy[s] = 2; end
        if (baLatchOpen[s]) begin mBa[s] = bIn[s*WIDTH +: WIDTH]; mBaWhy[s] = 1; end
        else if (mBaPrev[s] && !baCapture[s]) begin mBa[s] = bIn[s*WIDTH +: WIDTH]; mBaWhy[s] = 2; end
      end
    end
    if (!rstN) begin mAbPrev = '0; mBaPrev = '0; end
    else begin mAbPrev = abCapture; mBaPrev = baCapture; end
  end

  task automatic check(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pickTag(input bit drv, input bit isAb, input bit le, input int why);
    if (!drv)      return isAb ? "R4" : "R5";
    if (le)        return "R1";
    if (why == 2)  return "R3";
    if (why == 1)  return "R7";
    return "R2";
  endfunction

  // R6: every section is compared on its own slice against its own controls
  task automatic checkAll();
    for (int s = 0; s < SECTIONS; s++) begin
      logic [WIDTH-1:0] expB, expA;
      expB = !abEnable[s] ? '0 : (abLatchOpen[s] ? aIn[s*WIDTH +: WIDTH] : mAb[s]);
      expA = baEnableN[s] ? '0 : (baLatchOpen[s] ? bIn[s*WIDTH +: WIDTH] : mBa[s]);
      check({pickTag(abEnable[s], 1, abLatchOpen[s], mAbWhy[s]), " R6 bOut"},
            bOut[s*WIDTH +: WIDTH], expB);
      check({pickTag(!baEnableN[s], 0, baLatchOpen[s], mBaWhy[s]), " R6 aOut"},
            aOut[s*WIDTH +: WIDTH], expA);
      check("R4 bDrive", WIDTH'(bDrive[s]), WIDTH'(abEnable[s]));
      check("R5 aDrive", WIDTH'(aDrive[s]), WIDTH'(!baEnableN[s]));
      check("R8 contention", WIDTH'(contention[s]), WIDTH'(abEnable[s] && !baEnableN[s]));
    end
  endtask

  task automatic randomDrive();
    logic [63:0] ra, rb;
    ra = {$urandom(), $urandom()};
    rb = {$urandom(), $urandom()};
    aIn = ra[TOTAL-1:0];
    bIn = rb[TOTAL-1:0];
    for (int s = 0; s < SECTIONS; s++) begin
      abLatchOpen[s] = ($urandom() % 4) == 0;
      baLatchOpen[s] = ($urandom() % 4) == 0;
      if ($urandom() % 2 == 0) abCapture[s] = ~abCapture[s];
      if ($urandom() % 2 == 0) baCapture[s] = ~baCapture[s];
      abEnable[s]  = ($urandom() % 5) != 0;
      baEnableN[s] = ($urandom() % 5) == 0;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  initial begin
    rstN = 1'b1;
    abEnable = '1; baEnableN = '0;
    abLatchOpen = '0; baLatchOpen = '0;
    abCapture = '0; baCapture = '0;
    aIn = '1; bIn = '1;
    #2 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state, latches closed, both directions enabled
    checkAll();
    for (int s = 0; s < SECTIONS; s++) begin
      check("R9 reset bOut", bOut[s*WIDTH +: WIDTH], '0);
      check("R9 reset aOut", aOut[s*WIDTH +: WIDTH], '0);
    end
    // R9: capture left high through reset release must not store on the first edge
    abCapture = '1;
    @(negedge clk);
    rstN = 1'b1;
    abCapture = '0;
    @(negedge clk);
    for (int s = 0; s < SECTIONS; s++)
      check("R9 no false fall", bOut[s*WIDTH +: WIDTH], '0);
    checkAll();
    for (int c = 0; c < CYCLES; c++) begin
      @(negedge clk);
      checkAll();
      if (c == CYCLES / 2) begin
        rstN = 1'b0;
        @(negedge clk);
        for (int s = 0; s < SECTIONS; s++) begin
          check("R9 mid reset bOut", bOut[s*WIDTH +: WIDTH],
                (abEnable[s] && abLatchOpen[s]) ? aIn[s*WIDTH +: WIDTH] : '0);
          check("R9 mid reset aOut", aOut[s*WIDTH +: WIDTH],
                (!baEnableN[s] && baLatchOpen[s]) ? bIn[s*WIDTH +: WIDTH] : '0);
        end
        abCapture = '1; baCapture = '1;
        @(negedge clk);
        rstN = 1'b1;
      end else begin
        randomDrive();
      end
    end
    @(negedge clk);
    checkAll();
    summary();
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

endmodule